// File: doc/BRIEF.md
# Word-Buffered Serial EEPROM Slave

This block is the slave end of a two-wire serial link in front of a small nonvolatile store of 32 rows, each 16 bits wide. The store is modelled as a register file. The block watches the clock and data lines for START and STOP. It takes in a control byte that names a row, a two-bit mode code and a direction. Every access first copies the addressed row into a one-word buffer, and all serial traffic then goes through that buffer, one byte at a time, in the order the mode selects.

A write carries zero, one or two data bytes into the buffer. When a write with at least one data byte is closed by STOP, the buffer and row go to an internal programming sequencer. The sequencer commits the word after a fixed number of clock cycles. While it runs, the block stays silent: it withholds the acknowledge on any control byte, so the master can poll until the store is free. A read streams bytes for as long as the master keeps acknowledging. After each full word it moves to the next or previous row, wrapping around the row space.

Top module: `eew_top`

## Requirements
- R1: After reset the block does not pull the data line low, the busy output is low, and every row reads as all zeros (INIT_ONES = 0).
- R2: A control byte carries the row in bits 7:3, the mode code in bits 2:1 and the direction in bit 0 (0 = write, 1 = read). When the sequencer is idle, the block acknowledges it by pulling the data line low during the ninth clock.
- R3: The mode code sets the byte order within a word. Code 01 sends or receives the low byte first. Codes 10, 11 and 00 use the high byte first.
- R4: A two-byte write puts the first byte into the first position of the order and the second byte into the second position. STOP then raises busy within a few cycles, and the new word is read back afterwards.
- R5: A one-byte write replaces only the byte in the first position. The other byte keeps the value the row held before.
- R6: A write with a control byte and no data byte, closed by STOP, starts no programming cycle. Busy stays low.
- R7: Busy stays high for exactly PROG_CYCLES clock cycles. During that time the data line is never pulled low, and a control byte gets no acknowledge.
- R8: A read continues for any number of bytes. After each second byte of a word, the row steps by -1 for mode 00 and by +1 for the other codes, modulo the number of rows.
- R9: Once the master answers a read byte with NACK, the block releases the data line and sends nothing until the next START. The data line changes only while the clock is low.
- R10: A third data byte in one write gets no acknowledge and leaves the programmed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, as seen at the pad |
| sda_i | input | 1 | Serial data line, as seen at the pad |
| sda_drive_low_o | output | 1 | 1 pulls the open-drain data line low |
| prog_busy_o | output | 1 | High while the programming sequencer runs |

## Verification
The bench builds the block with ROW_BITS = 5, SYNC_STAGES = 3, INIT_ONES = 0 and PROG_CYCLES = 600. The short programming time means a polling control byte lands inside the busy window and is refused, and many write-then-read rounds fit in one run. The full five-bit row space makes reads that start at rows 30 and 1 cross the wrap at both ends. The deeper synchronizer checks that acknowledge and data timing still hold with the added input latency.

// File: rtl/eew_pkg.sv
package eew_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   localparam logic [1:0] MODE_DEC     = 2'b00;
   localparam logic [1:0] MODE_LOFIRST = 2'b01;
   localparam logic [1:0] MODE_HIFIRST = 2'b10;
   localparam logic [1:0] MODE_INC     = 2'b11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_HOLD
   } eew_state_e;

   // byte at order position pos (0 = first) of a word under mode m
   function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] m,
                                                   input logic pos);
      logic take_hi;
      take_hi = (m == MODE_LOFIRST) ? pos : ~pos;
      return take_hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
   endfunction

   function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] m,
                                                  input logic pos,
                                                  input logic [BYTE_W-1:0] b);
      logic take_hi;
      logic [WORD_W-1:0] r;
      take_hi = (m == MODE_LOFIRST) ? pos : ~pos;
      r = w;
      if (take_hi) r[WORD_W-1:BYTE_W] = b;
      else         r[BYTE_W-1:0]      = b;
      return r;
   endfunction

endpackage

// File: rtl/eew_line_cond.sv
module eew_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_q;
   logic [SYNC_STAGES-1:0] sda_q;
   logic                   scl_d;
   logic                   sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
         sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
         scl_d <= scl_q[SYNC_STAGES-1];
         sda_d <= sda_q[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_q[SYNC_STAGES-1];
   assign sda_s     = sda_q[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eew_store.sv
module eew_store import eew_pkg::*; #(
   parameter int ROW_BITS    = 5,
   parameter int PROG_CYCLES = 500000,
   parameter bit INIT_ONES   = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [ROW_BITS-1:0] req_row,
   input  logic [WORD_W-1:0]   req_word,
   input  logic [ROW_BITS-1:0] rd_row,
   output logic [WORD_W-1:0]   rd_word,
   output logic                busy
);

   localparam int ROWS = 1 << ROW_BITS;
   localparam int CW   = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
   localparam logic [WORD_W-1:0] INIT_WORD = INIT_ONES ? '1 : '0;

   logic [CW-1:0]       cnt;
   logic [ROW_BITS-1:0] p_row;
   logic [WORD_W-1:0]   p_word;
   logic                commit;
   logic [WORD_W-1:0]   rows_q [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         p_row  <= '0;
         p_word <= '0;
      end else if (req && !busy) begin
         busy   <= 1'b1;
         cnt    <= CW'(PROG_CYCLES - 1);
         p_row  <= req_row;
         p_word <= req_word;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign commit = busy && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) rows_q[r] <= INIT_WORD;
      end else if (commit) begin
         rows_q[p_row] <= p_word;
      end
   end

   assign rd_word = rows_q[rd_row];

endmodule

// File: rtl/eew_link.sv
module eew_link import eew_pkg::*; #(
   parameter int ROW_BITS = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scl_rise,
   input  logic                scl_fall,
   input  logic                start_det,
   input  logic                stop_det,
   input  logic                sda_s,
   input  logic                busy,
   input  logic [WORD_W-1:0]   rd_word,
   output logic [ROW_BITS-1:0] rd_row,
   output logic                sda_drive,
   output logic                prog_req,
   output logic [ROW_BITS-1:0] prog_row,
   output logic [WORD_W-1:0]   prog_word,
   output logic [1:0]          n_data
);

   localparam int ROW_LSB = 3;

   eew_state_e          state;
   logic [2:0]          bit_cnt;
   logic                done;
   logic [BYTE_W-1:0]   sh;
   logic [BYTE_W-1:0]   tx;
   logic                is_ctrl;
   logic                is_rd;
   logic                wr_sess;
   logic                pos;
   logic                m_ack;
   logic [1:0]          mode;
   logic [ROW_BITS-1:0] row;
   logic [ROW_BITS-1:0] row_step;
   logic [WORD_W-1:0]   word_q;
   logic [BYTE_W-1:0]   next_tx;

   assign row_step = (mode == MODE_DEC) ? row - 1'b1 : row + 1'b1;
   assign rd_row   = (state == ST_MACK) ? row_step : row;
   assign next_tx  = (state == ST_MACK && !pos) ? pick_byte(word_q, mode, 1'b1)
                                                : pick_byte(rd_word, mode, 1'b0);
   assign prog_row  = row;
   assign prog_word = word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         done      <= 1'b0;
         sh        <= '0;
         tx        <= '0;
         is_ctrl   <= 1'b0;
         is_rd     <= 1'b0;
         wr_sess   <= 1'b0;
         pos       <= 1'b0;
         m_ack     <= 1'b0;
         mode      <= '0;
         row       <= '0;
         word_q    <= '0;
         n_data    <= '0;
         sda_drive <= 1'b0;
         prog_req  <= 1'b0;
      end else begin
         prog_req <= 1'b0;
         if (start_det) begin
            state     <= ST_RX;
            is_ctrl   <= 1'b1;
            bit_cnt   <= '0;
            done      <= 1'b0;
            n_data    <= '0;
            wr_sess   <= 1'b0;
            sda_drive <= 1'b0;
         end else if (stop_det) begin
            prog_req  <= wr_sess && (n_data != 2'd0);
            wr_sess   <= 1'b0;
            state     <= ST_IDLE;
            sda_drive <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     sh      <= {sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) done <= 1'b1;
                  end else if (scl_fall && done) begin
                     done    <= 1'b0;
                     bit_cnt <= '0;
                     if (is_ctrl) begin
                        if (busy) begin
                           state <= ST_HOLD;
                        end else begin
                           row       <= sh[ROW_LSB +: ROW_BITS];
                           mode      <= sh[2:1];
                           is_rd     <= sh[0];
                           wr_sess   <= ~sh[0];
                           sda_drive <= 1'b1;
                           state     <= ST_ACK;
                        end
                     end else if (n_data != 2'd2) begin
                        word_q    <= put_byte(word_q, mode, n_data[0], sh);
                        n_data    <= n_data + 2'd1;
                        sda_drive <= 1'b1;
                        state     <= ST_ACK;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_drive <= 1'b0;
                     bit_cnt   <= '0;
                     state     <= ST_RX;
                     if (is_ctrl) begin
                        is_ctrl <= 1'b0;
                        word_q  <= rd_word;
                        if (is_rd) begin
                           tx        <= next_tx;
                           pos       <= 1'b0;
                           sda_drive <= ~next_tx[BYTE_W-1];
                           state     <= ST_TX;
                        end
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 3'd1;
                     if (bit_cnt == 3'd7) done <= 1'b1;
                  end else if (scl_fall) begin
                     if (done) begin
                        done      <= 1'b0;
                        bit_cnt   <= '0;
                        sda_drive <= 1'b0;
                        m_ack     <= 1'b0;
                        state     <= ST_MACK;
                     end else begin
                        tx        <= {tx[BYTE_W-2:0], 1'b0};
                        sda_drive <= ~tx[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     if (sda_s) state <= ST_HOLD;
                     else       m_ack <= 1'b1;
                  end else if (scl_fall && m_ack) begin
                     m_ack     <= 1'b0;
                     tx        <= next_tx;
                     sda_drive <= ~next_tx[BYTE_W-1];
                     state     <= ST_TX;
                     if (pos) begin
                        row    <= row_step;
                        word_q <= rd_word;
                        pos    <= 1'b0;
                     end else begin
                        pos <= 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/eew_top.sv
module eew_top import eew_pkg::*; #(
   parameter int ROW_BITS    = 5,
   parameter int PROG_CYCLES = 500000,
   parameter int SYNC_STAGES = 2,
   parameter bit INIT_ONES   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_drive_low_o,
   output logic prog_busy_o
);

   if (ROW_BITS < 1 || ROW_BITS > 5) begin : g_bad_rows
      $error("eew_top: ROW_BITS must be 1..5, the control byte holds five row bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("eew_top: SYNC_STAGES must be at least 2");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("eew_top: PROG_CYCLES must be at least 1");
   end

   logic                scl_s;
   logic                sda_s;
   logic                scl_rise;
   logic                scl_fall;
   logic                start_det;
   logic                stop_det;
   logic                busy;
   logic                prog_req;
   logic [ROW_BITS-1:0] rd_row;
   logic [ROW_BITS-1:0] prog_row;
   logic [WORD_W-1:0]   rd_word;
   logic [WORD_W-1:0]   prog_word;
   logic [1:0]          n_data;

   eew_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   eew_link #(.ROW_BITS(ROW_BITS)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .busy      (busy),
      .rd_word   (rd_word),
      .rd_row    (rd_row),
      .sda_drive (sda_drive_low_o),
      .prog_req  (prog_req),
      .prog_row  (prog_row),
      .prog_word (prog_word),
      .n_data    (n_data)
   );

   eew_store #(
      .ROW_BITS    (ROW_BITS),
      .PROG_CYCLES (PROG_CYCLES),
      .INIT_ONES   (INIT_ONES)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (prog_req),
      .req_row  (prog_row),
      .req_word (prog_word),
      .rd_row   (rd_row),
      .rd_word  (rd_word),
      .busy     (busy)
   );

   assign prog_busy_o = busy;

endmodule

// File: rtl/eew_chk.sv
module eew_chk #(
   parameter int PROG_CYCLES = 500000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sda_drive,
   input logic       busy,
   input logic       prog_req,
   input logic       scl_s,
   input logic       start_det,
   input logic       stop_det,
   input logic [1:0] n_data
);

   localparam int LW = $clog2(PROG_CYCLES + 2);

   logic [LW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_drive); // R7

   AST_REQ_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> !busy); // R7

   AST_BUSY_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == LW'(PROG_CYCLES))); // R7

   AST_REQ_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> busy); // R4

   AST_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> (n_data != 2'd0)); // R6

   AST_DATA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
         |-> $stable(sda_drive)); // R9

endmodule

bind eew_top eew_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sda_drive (sda_drive_low_o),
   .busy      (prog_busy_o),
   .prog_req  (prog_req),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .n_data    (n_data)
);

// File: tb/tb_eew_top.sv
module tb_eew_top;

   localparam int ROW_BITS = 5;
   localparam int ROWS     = 1 << ROW_BITS;
   localparam int PROG     = 600;
   localparam int Q        = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic drv;
   logic busy;
   wire  line = sda_m & ~drv;

   int n_run = 0;
   int n_fail = 0;
   logic [15:0] ref_mem [ROWS];

   int busy_run = 0;
   int last_len = 0;
   bit busy_seen = 1'b0;

   always #10 clk = ~clk;

   eew_top #(
      .ROW_BITS    (ROW_BITS),
      .PROG_CYCLES (PROG),
      .SYNC_STAGES (3),
      .INIT_ONES   (1'b0)
   ) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl_m),
      .sda_i           (line),
      .sda_drive_low_o (drv),
      .prog_busy_o     (busy)
   );

   always @(negedge clk) begin
      if (busy) begin
         busy_run++;
         busy_seen = 1'b1;
      end else begin
         if (busy_run != 0) last_len = busy_run;
         busy_run = 0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_q(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; wait_q(1);
      scl_m = 1'b1; wait_q(1);
      sda_m = 1'b0; wait_q(1);
      scl_m = 1'b0; wait_q(1);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; wait_q(1);
      scl_m = 1'b1; wait_q(1);
      sda_m = 1'b1; wait_q(2);
   endtask

   task automatic bit_out(input logic b);
      sda_m = b; wait_q(1);
      scl_m = 1'b1; wait_q(2);
      scl_m = 1'b0; wait_q(1);
   endtask

   task automatic bit_in(output logic b);
      sda_m = 1'b1; wait_q(1);
      scl_m = 1'b1; wait_q(1);
      b = line; wait_q(1);
      scl_m = 1'b0; wait_q(1);
   endtask

   task automatic byte_out(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
      bit_in(b);
      ack = ~b;
   endtask

   task automatic byte_in(input logic mack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         v[i] = b;
      end
      bit_out(~mack);
   endtask

   function automatic logic [7:0] exp_byte(input logic [15:0] w, input logic [1:0] m, input logic p);
      logic hi;
      hi = (m == 2'b01) ? p : ~p;
      return hi ? w[15:8] : w[7:0];
   endfunction

   function automatic logic [15:0] set_byte(input logic [15:0] w, input logic [1:0] m, input logic p,
                                            input logic [7:0] b);
      logic [15:0] r;
      r = w;
      if ((m == 2'b01) ? p : ~p) r[15:8] = b;
      else                       r[7:0]  = b;
      return r;
   endfunction

   function automatic logic [7:0] ctrl(input int row, input logic [1:0] m, input logic rd);
      return {5'(row), m, rd};
   endfunction

   // write of nb data bytes; optional poll while busy
   task automatic wr_txn(input int row, input logic [1:0] m, input int nb,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input bit poll);
      logic ack;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      m_start();
      byte_out(ctrl(row, m, 1'b0), ack);
      chk("R2 control ack", ack, 1);
      for (int i = 0; i < nb; i++) begin
         byte_out(d[i], ack);
         if (i < 2) chk("R4 data ack", ack, 1);
         else       chk("R10 third byte nack", ack, 0);
      end
      busy_seen = 1'b0;
      m_stop();
      if (nb > 0) begin
         for (int i = 0; i < nb && i < 2; i++)
            ref_mem[row] = set_byte(ref_mem[row], m, i[0], d[i]);
         chk("R4 busy after stop", busy, 1);
         if (poll) begin
            m_start();
            byte_out(ctrl(row, m, 1'b0), ack);
            chk("R7 control nack while busy", ack, 0);
            m_stop();
         end
         while (busy) @(negedge clk);
         @(negedge clk);
         chk("R7 busy length", last_len, PROG);
         if (poll) begin
            m_start();
            byte_out(ctrl(row, m, 1'b0), ack);
            chk("R7 control ack after busy", ack, 1);
            m_stop();
         end
      end else begin
         repeat (40) @(negedge clk);
         chk("R6 no programming", busy_seen, 0);
      end
   endtask

   task automatic rd_txn(input int row, input logic [1:0] m, input int nb, input string req);
      logic ack;
      logic [7:0] v;
      int r;
      logic p;
      r = row;
      p = 1'b0;
      m_start();
      byte_out(ctrl(row, m, 1'b1), ack);
      chk("R2 read control ack", ack, 1);
      for (int k = 0; k < nb; k++) begin
         byte_in(k != nb - 1, v);
         chk(req, v, exp_byte(ref_mem[r], m, p));
         if (p) r = (m == 2'b00) ? (r + ROWS - 1) % ROWS : (r + 1) % ROWS;
         p = ~p;
      end
      m_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic ack;
      logic [7:0] v;
      void'($urandom(32'h5EED));
      for (int i = 0; i < ROWS; i++) ref_mem[i] = 16'h0000;
      repeat (5) @(negedge clk);
      chk("R1 no drive in reset", drv, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 no drive after reset", drv, 0);
      chk("R1 busy low after reset", busy, 0);
      rd_txn(5, 2'b10, 2, "R1 row reads zero");

      // two-byte write, high first, with polling
      wr_txn(3, 2'b10, 2, 8'hA5, 8'h3C, 8'h00, 1'b1);
      chk("R4 stored word", ref_mem[3], 16'hA53C);
      rd_txn(3, 2'b10, 2, "R3 high byte first");
      rd_txn(3, 2'b01, 2, "R3 low byte first");

      // one-byte write, low first
      wr_txn(3, 2'b01, 1, 8'h77, 8'h00, 8'h00, 1'b0);
      chk("R5 model word", ref_mem[3], 16'hA577);
      rd_txn(3, 2'b10, 2, "R5 other byte kept");

      // control-only write
      wr_txn(9, 2'b10, 0, 8'h00, 8'h00, 8'h00, 1'b0);
      rd_txn(9, 2'b10, 2, "R6 row unchanged");

      // three data bytes
      wr_txn(12, 2'b10, 3, 8'h12, 8'h34, 8'hFF, 1'b0);
      rd_txn(12, 2'b10, 2, "R10 third byte ignored");

      // wrap at both ends
      wr_txn(31, 2'b10, 2, 8'hBE, 8'hEF, 8'h00, 1'b0);
      wr_txn(0, 2'b01, 2, 8'h11, 8'h22, 8'h00, 1'b0);
      wr_txn(30, 2'b11, 2, 8'h5A, 8'hC3, 8'h00, 1'b0);
      rd_txn(30, 2'b11, 6, "R8 increment wrap");
      rd_txn(1, 2'b00, 6, "R8 decrement wrap");
      rd_txn(31, 2'b01, 4, "R8 step in low-first mode");

      // master NACK stops the stream
      m_start();
      byte_out(ctrl(3, 2'b10, 1'b1), ack);
      chk("R2 read control ack", ack, 1);
      byte_in(1'b0, v);
      chk("R9 first byte", v, 8'hA5);
      byte_in(1'b0, v);
      chk("R9 line released after nack", v, 8'hFF);
      m_stop();

      // random mix
      for (int it = 0; it < 30; it++) begin
         int row;
         logic [1:0] m;
         row = $urandom % ROWS;
         m = 2'($urandom);
         if ($urandom % 2 == 0)
            wr_txn(row, m, $urandom % 4, 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
         else
            rd_txn(row, m, 1 + $urandom % 5, "R8 random read");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule